// File: doc/BRIEF.md
# UART Interrupt Request Controller

This block turns the status of a UART's datapath into one interrupt request line and a source code that software reads to learn why it was interrupted. It watches the transmit holding register and shift register, the receive FIFO fill level and its push and pop strobes, the receive line error detectors and a modem status change strobe. Each source can be masked by its own enable bit. The exception is receive data and receive time-out, which share one enable.

The receive time-out is measured by a small state machine that counts character periods from a one-per-character tick. It has three states. In `TO_IDLE` the FIFO is not eligible. The transition `TO_IDLE -> TO_COUNT` is taken when, in FIFO mode, the count is nonzero, the count is below the trigger level and there is no push or pop. The transition `TO_COUNT -> TO_IDLE` is taken on any push or pop, or when the count leaves that window. The transition `TO_COUNT -> TO_FIRED` is taken on the fourth tick. In `TO_FIRED` the time-out is pending. The transition `TO_FIRED -> TO_IDLE` is taken only when the FIFO count reaches zero.

The request output and the source code are registered, so both update one clock after the pending state changes.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `irq_id` is 0.
- R2: Receive data ready is pending when `fifo_en`=1 and `rx_count` >= trigger level, or when `fifo_en`=0 and `rx_count` != 0. The `trig_sel` values 0, 1, 2 and 3 select levels of 1, 4, 8 and 14 bytes.
- R3: Receive time-out becomes pending after 4 `char_tick` pulses with `fifo_en`=1, 0 < `rx_count` < trigger level, and no `rx_push` or `rx_pop`. Any push or pop restarts the count.
- R4: Once pending, the time-out stays pending through pushes and pops until `rx_count` is 0. It never arises while `fifo_en`=0.
- R5: `en_rx` gates both receive data ready and receive time-out.
- R6: Transmit holding empty is set on a rising edge of `thr_empty` and cleared by `thr_write`. Its enable is `en_thre`.
- R7: Transmission complete is set by a `tsr_done` pulse and cleared by `thr_write`. Its enable is `en_txdone`.
- R8: The line status source is set by any pulse on `par_err`, `frm_err`, `ovr_err` or `brk_det`, and cleared by `lsr_read`. A new error in the same cycle as the read wins.
- R9: With `nine_bit`=1, `par_err` does not set the line status source (it marks an address byte).
- R10: The modem source is set by `msr_change` and cleared by `msr_read`.
- R11: `irq_id` gives the highest enabled pending source. The codes are 1 line status, 2 receive data, 3 receive time-out, 4 transmit holding empty, 5 transmission complete, 6 modem, and 0 for none. Priority follows that numeric order, lowest code first.
- R12: `irq` is the OR of the enabled pending sources, registered one cycle. A masked source stays pending and appears once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_en | input | 1 | Receive FIFO mode |
| trig_sel | input | 2 | Trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | FIFO write strobe |
| rx_pop | input | 1 | FIFO read strobe |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Holding register empty status |
| thr_write | input | 1 | Software write to holding register |
| tsr_done | input | 1 | Shift register finished pulse |
| par_err | input | 1 | Parity mismatch pulse |
| frm_err | input | 1 | Missing stop bit pulse |
| ovr_err | input | 1 | Overrun pulse |
| brk_det | input | 1 | Break detected pulse |
| nine_bit | input | 1 | 9-bit data mode |
| lsr_read | input | 1 | Line status read strobe |
| msr_change | input | 1 | Modem status change pulse |
| msr_read | input | 1 | Modem status read strobe |
| en_rx | input | 1 | Receive data / time-out enable |
| en_thre | input | 1 | Holding empty enable |
| en_txdone | input | 1 | Transmission complete enable |
| en_line | input | 1 | Line status enable |
| en_modem | input | 1 | Modem status enable |
| irq | output | 1 | Registered interrupt request |
| irq_id | output | 3 | Registered source code |

## Verification
The hardest state to reach is `TO_FIRED`. The FIFO must sit inside the window between empty and the trigger level, with no FIFO traffic, for exactly four character ticks. The bench holds `rx_count` in that window and delivers three ticks. It then injects a push and checks that a fresh run of three ticks still does not fire. Only the fourth tick of the new run fires, and the bench checks the registered output on both sides of that edge. It then walks the count up past the trigger level and back down, to show the time-out persists until the FIFO is empty. It also shows that non-FIFO mode never leaves a fired state behind.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 6;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_LINE   = 3'd1,
        SRC_RXDATA = 3'd2,
        SRC_RXTO   = 3'd3,
        SRC_THRE   = 3'd4,
        SRC_TXDONE = 3'd5,
        SRC_MODEM  = 3'd6
    } irq_src_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

endpackage

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto
    import uart_irq_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output logic             to_pend,
    output to_state_e        state_o
);

    localparam int TCW = (TO_CHARS > 1) ? $clog2(TO_CHARS) : 1;
    localparam logic [TCW-1:0] LAST_TICK = TCW'(TO_CHARS - 1);

    to_state_e      state_q, state_d;
    logic [TCW-1:0] ticks_q, ticks_d;
    logic           eligible;

    assign eligible = fifo_en && (rx_count != '0) && (rx_count < trig_lvl)
                      && !rx_push && !rx_pop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            ticks_q <= '0;
        end else begin
            state_q <= state_d;
            ticks_q <= ticks_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ticks_d = ticks_q;
        unique case (state_q)
            TO_IDLE: begin
                ticks_d = '0;
                if (eligible) state_d = TO_COUNT;
            end
            TO_COUNT: begin
                if (!eligible) begin
                    state_d = TO_IDLE;
                    ticks_d = '0;
                end else if (char_tick) begin
                    if (ticks_q == LAST_TICK) begin
                        state_d = TO_FIRED;
                        ticks_d = '0;
                    end else begin
                        ticks_d = ticks_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                ticks_d = '0;
                if (rx_count == '0) state_d = TO_IDLE;
            end
            default: begin
                state_d = TO_IDLE;
                ticks_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        to_pend = (state_q == TO_FIRED) && (rx_count != '0);
        state_o = state_q;
    end

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic thr_write,
    input  logic tsr_done,
    input  logic par_err,
    input  logic frm_err,
    input  logic ovr_err,
    input  logic brk_det,
    input  logic nine_bit,
    input  logic lsr_read,
    input  logic msr_change,
    input  logic msr_read,
    output logic thre_flag,
    output logic txdone_flag,
    output logic line_flag,
    output logic modem_flag
);

    logic thr_empty_q;
    logic thre_rise;
    logic line_hit;

    assign thre_rise = thr_empty && !thr_empty_q;
    assign line_hit  = frm_err || ovr_err || brk_det || (par_err && !nine_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_empty_q <= 1'b1;
            thre_flag   <= 1'b0;
            txdone_flag <= 1'b0;
            line_flag   <= 1'b0;
            modem_flag  <= 1'b0;
        end else begin
            thr_empty_q <= thr_empty;
            // a write to the holding register clears both transmit sources
            if (thr_write)      thre_flag <= 1'b0;
            else if (thre_rise) thre_flag <= 1'b1;
            if (thr_write)      txdone_flag <= 1'b0;
            else if (tsr_done)  txdone_flag <= 1'b1;
            // a new event beats a simultaneous read so nothing is lost
            if (line_hit)       line_flag <= 1'b1;
            else if (lsr_read)  line_flag <= 1'b0;
            if (msr_change)     modem_flag <= 1'b1;
            else if (msr_read)  modem_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output irq_src_e           id,
    output logic               any
);

    always_comb begin
        id  = SRC_NONE;
        any = |pend;
        // scan from lowest priority so the highest one is written last
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) id = irq_src_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4,
    parameter int TRIG_L0    = 1,
    parameter int TRIG_L1    = 4,
    parameter int TRIG_L2    = 8,
    parameter int TRIG_L3    = 14,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             thr_empty,
    input  logic             thr_write,
    input  logic             tsr_done,
    input  logic             par_err,
    input  logic             frm_err,
    input  logic             ovr_err,
    input  logic             brk_det,
    input  logic             nine_bit,
    input  logic             lsr_read,
    input  logic             msr_change,
    input  logic             msr_read,
    input  logic             en_rx,
    input  logic             en_thre,
    input  logic             en_txdone,
    input  logic             en_line,
    input  logic             en_modem,
    output logic             irq,
    output logic [2:0]       irq_id
);

    logic [CNT_W-1:0]   trig_lvl;
    logic               rx_ready;
    logic               to_pend;
    to_state_e          to_state;
    logic               thre_flag, txdone_flag, line_flag, modem_flag;
    logic [NUM_SRC-1:0] pend;
    irq_src_e           id_comb;
    logic               any_comb;
    irq_src_e           id_q;

    always_comb begin
        unique case (trig_sel)
            2'd0: trig_lvl = CNT_W'(TRIG_L0);
            2'd1: trig_lvl = CNT_W'(TRIG_L1);
            2'd2: trig_lvl = CNT_W'(TRIG_L2);
            2'd3: trig_lvl = CNT_W'(TRIG_L3);
            default: trig_lvl = CNT_W'(TRIG_L0);
        endcase
    end

    assign rx_ready = fifo_en ? (rx_count >= trig_lvl) : (rx_count != '0);

    uart_irq_rxto #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) u_rxto (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .trig_lvl  (trig_lvl),
        .rx_push   (rx_push),
        .rx_pop    (rx_pop),
        .char_tick (char_tick),
        .to_pend   (to_pend),
        .state_o   (to_state)
    );

    uart_irq_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_empty   (thr_empty),
        .thr_write   (thr_write),
        .tsr_done    (tsr_done),
        .par_err     (par_err),
        .frm_err     (frm_err),
        .ovr_err     (ovr_err),
        .brk_det     (brk_det),
        .nine_bit    (nine_bit),
        .lsr_read    (lsr_read),
        .msr_change  (msr_change),
        .msr_read    (msr_read),
        .thre_flag   (thre_flag),
        .txdone_flag (txdone_flag),
        .line_flag   (line_flag),
        .modem_flag  (modem_flag)
    );

    // bit i carries source code i+1
    assign pend = { modem_flag  && en_modem,
                    txdone_flag && en_txdone,
                    thre_flag   && en_thre,
                    to_pend     && en_rx,
                    rx_ready    && en_rx,
                    line_flag   && en_line };

    uart_irq_prio u_prio (
        .pend (pend),
        .id   (id_comb),
        .any  (any_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            id_q <= SRC_NONE;
        end else begin
            irq  <= any_comb;
            id_q <= id_comb;
        end
    end

    assign irq_id = id_q;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic             char_tick,
    input logic             thr_write,
    input logic             par_err,
    input logic             frm_err,
    input logic             ovr_err,
    input logic             brk_det,
    input logic             nine_bit,
    input logic             en_rx,
    input logic             en_thre,
    input logic             en_txdone,
    input logic             en_line,
    input logic             en_modem,
    input logic             irq,
    input logic [2:0]       irq_id,
    input logic             thre_flag,
    input logic             line_flag,
    input to_state_e        to_state
);

    AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ({en_rx, en_thre, en_txdone, en_line, en_modem} == 5'b0) |=> !irq); // R12

    AST_RXTO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id == SRC_RXTO) |-> ($past(rx_count) != '0)); // R4

    AST_TO_FIRES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (to_state == TO_COUNT && !char_tick) |=> (to_state != TO_FIRED)); // R3

    AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write |=> !thre_flag); // R6

    AST_LINE_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err || ovr_err || brk_det || (par_err && !nine_bit)) |=> line_flag); // R8

    AST_LINE_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_flag && en_line) |=> (irq_id == SRC_LINE)); // R11

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_count  (rx_count),
    .char_tick (char_tick),
    .thr_write (thr_write),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err),
    .brk_det   (brk_det),
    .nine_bit  (nine_bit),
    .en_rx     (en_rx),
    .en_thre   (en_thre),
    .en_txdone (en_txdone),
    .en_line   (en_line),
    .en_modem  (en_modem),
    .irq       (irq),
    .irq_id    (irq_id),
    .thre_flag (thre_flag),
    .line_flag (line_flag),
    .to_state  (to_state)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 0, rx_push = 0, rx_pop = 0, char_tick = 0;
    logic [1:0] trig_sel = 0;
    logic [4:0] rx_count = 0;
    logic       thr_empty = 0, thr_write = 0, tsr_done = 0;
    logic       par_err = 0, frm_err = 0, ovr_err = 0, brk_det = 0, nine_bit = 0;
    logic       lsr_read = 0, msr_change = 0, msr_read = 0;
    logic       en_rx = 0, en_thre = 0, en_txdone = 0, en_line = 0, en_modem = 0;
    logic       irq;
    logic [2:0] irq_id;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .thr_empty(thr_empty), .thr_write(thr_write),
        .tsr_done(tsr_done), .par_err(par_err), .frm_err(frm_err),
        .ovr_err(ovr_err), .brk_det(brk_det), .nine_bit(nine_bit),
        .lsr_read(lsr_read), .msr_change(msr_change), .msr_read(msr_read),
        .en_rx(en_rx), .en_thre(en_thre), .en_txdone(en_txdone),
        .en_line(en_line), .en_modem(en_modem), .irq(irq), .irq_id(irq_id)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int e_irq, input int e_id);
        chk({tag, " irq"}, int'(irq), e_irq);
        chk({tag, " id"}, int'(irq_id), e_id);
    endtask

    task automatic tick();
        char_tick = 1; step(1); char_tick = 0; step(1);
    endtask

    function automatic int level(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(2);
        chk_out("R1 reset", 0, 0);
        rst_n = 1;
        step(2);
        chk_out("R1 after release", 0, 0);

        // R2 sweep: mode x trigger x count
        en_rx = 1;
        for (int f = 0; f < 2; f++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c <= 16; c++) begin
                    int e;
                    fifo_en = f[0]; trig_sel = s[1:0]; rx_count = c[4:0];
                    step(2);
                    e = (f == 1) ? int'(c >= level(s)) : int'(c != 0);
                    chk("R2 data ready", int'(irq), e);
                    chk("R2 data id", int'(irq_id), e ? 2 : 0);
                end

        // R5 / R12 shared enable, masked source stays pending
        en_rx = 0; fifo_en = 1; trig_sel = 1; rx_count = 16;
        step(2);
        chk_out("R5 rx masked", 0, 0);
        en_rx = 1;
        step(1);
        chk_out("R12 unmask shows", 1, 2);

        // R3 time-out with restart
        rx_count = 2; step(2);
        chk_out("R3 below trigger", 0, 0);
        repeat (3) tick();
        chk_out("R3 three ticks", 0, 0);
        rx_push = 1; step(1); rx_push = 0; step(1);
        repeat (3) tick();
        chk_out("R3 restart after push", 0, 0);
        char_tick = 1; step(1); char_tick = 0;
        chk_out("R12 registered lag", 0, 0);
        step(1);
        chk_out("R3 fourth tick fires", 1, 3);

        // R4 persistence
        rx_pop = 1; step(1); rx_pop = 0; rx_push = 1; step(1); rx_push = 0; step(1);
        chk_out("R4 holds through traffic", 1, 3);
        rx_count = 5; step(2);
        chk_out("R4 data ready outranks", 1, 2);
        rx_count = 1; step(2);
        chk_out("R4 still pending", 1, 3);
        en_rx = 0; step(2);
        chk_out("R5 time-out masked", 0, 0);
        en_rx = 1; step(2);
        chk_out("R5 time-out unmasked", 1, 3);
        rx_count = 0; step(2);
        chk_out("R4 cleared on empty", 0, 0);

        // R4 no time-out in non-FIFO mode
        fifo_en = 0; rx_count = 1; step(1);
        repeat (6) tick();
        chk_out("R4 non-fifo data only", 1, 2);
        fifo_en = 1; trig_sel = 1; step(2);
        chk_out("R4 no leftover time-out", 0, 0);
        rx_count = 0; step(2);

        // R6 / R7 transmit
        en_thre = 1; en_txdone = 1;
        thr_empty = 1; step(2);
        chk_out("R6 holding empty", 1, 4);
        thr_write = 1; thr_empty = 0; step(1); thr_write = 0; step(1);
        chk_out("R6 cleared by write", 0, 0);
        tsr_done = 1; step(1); tsr_done = 0; step(1);
        chk_out("R7 tx complete", 1, 5);
        thr_empty = 1; step(2);
        chk_out("R11 thre over txdone", 1, 4);
        en_thre = 0; step(2);
        chk_out("R6 own enable", 1, 5);
        en_txdone = 0; step(2);
        chk_out("R7 own enable", 0, 0);
        en_thre = 1; en_txdone = 1; step(2);
        chk_out("R12 held while masked", 1, 4);
        thr_write = 1; thr_empty = 0; step(1); thr_write = 0; step(1);
        chk_out("R7 write clears both", 0, 0);

        // R8 / R9 line status
        en_line = 1;
        for (int nb = 0; nb < 2; nb++)
            for (int k = 0; k < 4; k++) begin
                int e;
                nine_bit = nb[0];
                par_err = (k == 0); frm_err = (k == 1); ovr_err = (k == 2); brk_det = (k == 3);
                step(1);
                par_err = 0; frm_err = 0; ovr_err = 0; brk_det = 0;
                step(1);
                e = (k == 0 && nb == 1) ? 0 : 1;
                chk(e ? "R8 line set" : "R9 parity ignored", int'(irq_id), e ? 1 : 0);
                lsr_read = 1; step(1); lsr_read = 0; step(1);
                chk("R8 line cleared", int'(irq_id), 0);
            end
        nine_bit = 0;
        frm_err = 1; lsr_read = 1; step(1); frm_err = 0; lsr_read = 0; step(1);
        chk("R8 error beats read", int'(irq_id), 1);
        lsr_read = 1; step(1); lsr_read = 0; step(1);

        // R10 modem
        en_modem = 1;
        msr_change = 1; step(1); msr_change = 0; step(1);
        chk_out("R10 modem set", 1, 6);
        msr_read = 1; step(1); msr_read = 0; step(1);
        chk_out("R10 modem cleared", 0, 0);

        // R11 priority sweep
        fifo_en = 0;
        for (int m = 0; m < 16; m++) begin
            int e;
            frm_err = m[0]; msr_change = m[3]; thr_empty = m[2]; rx_count = {4'b0, m[1]};
            step(1);
            frm_err = 0; msr_change = 0;
            step(2);
            e = m[0] ? 1 : m[1] ? 2 : m[2] ? 4 : m[3] ? 6 : 0;
            chk("R11 priority", int'(irq_id), e);
            chk("R12 any pending", int'(irq), int'(e != 0));
            lsr_read = 1; msr_read = 1; thr_write = 1; thr_empty = 0; rx_count = 0;
            step(1);
            lsr_read = 0; msr_read = 0; thr_write = 0;
            step(2);
            chk("R11 cleared", int'(irq_id), 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule